// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight interrupt request lines, keeps a record of which are waiting and which are being serviced, and raises a single interrupt line towards a processor. The processor answers with an acknowledge strobe. The block then marks the chosen request as in service and returns an 8-bit vector. Software talks to it through a byte-wide write bus with two addresses: a command port (address 0) and a data port (address 1). A short sequence of words sets the vector base and the cascade wiring. After that, data writes set the mask and a command word ends the current service.

Two copies can be chained. The interrupt output of a slave feeds one request input of a master. When the master acknowledges that input, it places the input number on a cascade bus during the acknowledge cycle. The slave whose programmed identity matches that number then supplies the vector in place of the master. The role is fixed at build time by a parameter. A request that comes from a slave is fully retired only when both devices have received an end-of-interrupt command, and the two commands may be sent in either order.

Top module: `cascade_pic`

## Requirements
- R1: From reset until an initialization sequence completes, the interrupt output stays low and an acknowledge produces no vector, whatever the request inputs do.
- R2: A command-port write with bit 4 set starts initialization from any state. It clears the pending, in-service and mask registers, so the mask is all enabled afterwards. In that word, bit 1 = 1 selects single mode, which has no third word, and bit 0 = 1 announces a fourth word. The following words arrive on the data port in order: base, cascade word (cascaded mode only), then mode word (only if announced).
- R3: The base word supplies vector bits [7:3], and its bits [2:0] are ignored. The vector returned equals {base[7:3], local input number}.
- R4: On a master, the cascade word is a bitmap of the inputs that carry a slave. In single mode this bitmap is empty. On a slave, bits [2:0] of the cascade word hold its identity.
- R5: Once running, each data-port write loads the mask. A 1 bit blocks that input from raising the interrupt, but its request stays pending and is serviced after it is unmasked.
- R6: A request is latched on a rising edge of its input and held until acknowledged. An input that stays high does not raise a second request.
- R7: Input 0 has the highest priority. The interrupt output is high when the lowest-numbered unmasked pending input has a lower number than every in-service input.
- R8: When the acknowledge is sampled high with the interrupt output high, the selected request moves from pending to in service. The vector is valid on the cycle after. An acknowledge with the interrupt output low is ignored.
- R9: A master that acknowledges a slave-carrying input returns no vector. In that same cycle it drives the input number on the cascade bus with the enable high. Only a slave whose identity matches, and whose own interrupt output is high, takes the acknowledge and returns its vector.
- R10: A running command-port write of 0x20 clears the lowest-numbered in-service bit. Other command words with bit 4 clear have no effect.
- R11: While the master's in-service bit for a slave input is set, a new request from that slave stays pending at the master and does not raise the master's interrupt output. It is raised only after the master receives its end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe for one cycle |
| busAddr | input | 1 | 0 selects the command port, 1 the data port |
| busData | input | 8 | Write data |
| irqIn | input | 8 | Request inputs, rising-edge sensitive |
| intAck | input | 1 | Acknowledge strobe from the processor |
| cascIn | input | 3 | Cascade number seen by a slave |
| cascEnIn | input | 1 | Cascade number valid, seen by a slave |
| intOut | output | 1 | Interrupt request to the processor or to a master |
| cascOut | output | 3 | Cascade number driven by a master |
| cascEnOut | output | 1 | Cascade number valid, driven by a master |
| vecOut | output | 8 | Interrupt vector |
| vecValid | output | 1 | Vector valid, one cycle after a taken acknowledge |

## Verification
The bench builds a master and slave pair and sweeps every master input and every slave input, checking vectors of the form base plus global number. A design that dropped the cascade hand-off, or answered from both devices, would return a wrong or missing vector. The bench also sends the slave's end-of-interrupt before the master's, then raises a new slave request while the master still has its cascade input in service. A design that let equal priority through would interrupt early at that point. It also covers nested priority, where a higher request must pre-empt a lower one and end-of-interrupt must retire the lowest-numbered bit first. Finally it covers requests held under mask, a level held high, a slave with a mismatched identity, and single mode with stray low bits in the base.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef struct packed {
    logic initStart;
    logic loadBase;
    logic loadCasc;
    logic loadMask;
    logic eoi;
    logic ready;
  } picStrobe_t;

  localparam logic [7:0] EOI_CODE = 8'h20;

endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busData,
  output picStrobe_t        strobe
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_RUN
  } ctlState_t;

  ctlState_t stateQ, stateD;
  logic      needModeQ, needModeD;
  logic      singleQ, singleD;
  logic      isCmd, isData;

  assign isCmd  = busWe && !busAddr;
  assign isData = busWe && busAddr;

  always_comb begin
    strobe    = '0;
    stateD    = stateQ;
    needModeD = needModeQ;
    singleD   = singleQ;
    if (isCmd && busData[4]) begin
      strobe.initStart = 1'b1;
      stateD           = ST_BASE;
      needModeD        = busData[0];
      singleD          = busData[1];
    end else begin
      unique case (stateQ)
        ST_BASE: if (isData) begin
          strobe.loadBase = 1'b1;
          if (!singleQ)       stateD = ST_CASC;
          else if (needModeQ) stateD = ST_MODE;
          else                stateD = ST_RUN;
        end
        ST_CASC: if (isData) begin
          strobe.loadCasc = 1'b1;
          stateD          = needModeQ ? ST_MODE : ST_RUN;
        end
        ST_MODE: if (isData) stateD = ST_RUN;
        ST_RUN: begin
          if (isData) strobe.loadMask = 1'b1;
          if (isCmd && busData == DATA_W'(EOI_CODE)) strobe.eoi = 1'b1;
        end
        default: ;
      endcase
    end
    strobe.ready = (stateQ == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      needModeQ <= 1'b0;
      singleQ   <= 1'b0;
    end else begin
      stateQ    <= stateD;
      needModeQ <= needModeD;
      singleQ   <= singleD;
    end
  end

  AST_CASC_ONLY_CASCADED: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CASC) |-> !singleQ); // R2

  AST_RUN_NEEDS_SEQUENCE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(stateQ == ST_RUN)) |-> ($past(stateQ) != ST_IDLE)); // R1

endmodule

// File: rtl/pic_dp.sv
module pic_dp
  import pic_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8,
  parameter bit MASTER = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  picStrobe_t                strobe,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [NUM_IN-1:0]         irqIn,
  input  logic                      intAck,
  input  logic [$clog2(NUM_IN)-1:0] cascIn,
  input  logic                      cascEnIn,
  output logic                      intOut,
  output logic [$clog2(NUM_IN)-1:0] cascOut,
  output logic                      cascEnOut,
  output logic [DATA_W-1:0]         vecOut,
  output logic                      vecValid
);

  localparam int IDX_W  = $clog2(NUM_IN);
  localparam int BASE_W = DATA_W - IDX_W;

  logic [NUM_IN-1:0] irrQ, isrQ, imrQ, cascQ, irqPrevQ;
  logic [BASE_W-1:0] baseQ;
  logic [NUM_IN-1:0] candV, rise, ackMask, isrAfterEoi;
  logic              candAny, isrAny, reqOk, ackHit, giveVec;
  logic [IDX_W-1:0]  candIdx, isrIdx;

  function automatic logic [IDX_W:0] lowestSet(input logic [NUM_IN-1:0] v);
    logic [IDX_W:0] res;
    res = '0;
    for (int k = NUM_IN - 1; k >= 0; k--) begin
      if (v[k]) res = {1'b1, IDX_W'(k)};
    end
    return res;
  endfunction

  assign candV              = irrQ & ~imrQ;
  assign {candAny, candIdx} = lowestSet(candV);
  assign {isrAny, isrIdx}   = lowestSet(isrQ);
  assign reqOk              = candAny && (!isrAny || candIdx < isrIdx);
  assign intOut             = strobe.ready && reqOk;
  assign rise               = irqIn & ~irqPrevQ;
  assign ackMask            = ackHit ? (NUM_IN'(1) << candIdx) : '0;
  assign isrAfterEoi        = strobe.eoi ? (isrQ & (isrQ - NUM_IN'(1))) : isrQ;

  generate
    if (MASTER) begin : g_master
      logic unusedCascIn;
      assign unusedCascIn = ^{cascIn, cascEnIn};
      assign ackHit       = intAck && intOut;
      assign cascOut      = candIdx;
      assign cascEnOut    = ackHit && cascQ[candIdx];
      assign giveVec      = ackHit && !cascQ[candIdx];
    end else begin : g_slave
      logic unusedCascHi;
      assign unusedCascHi = ^cascQ[NUM_IN-1:IDX_W];
      assign ackHit       = intAck && intOut && cascEnIn && (cascIn == cascQ[IDX_W-1:0]);
      assign cascOut      = '0;
      assign cascEnOut    = 1'b0;
      assign giveVec      = ackHit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irrQ     <= '0;
      isrQ     <= '0;
      imrQ     <= '1;
      cascQ    <= '0;
      baseQ    <= '0;
      irqPrevQ <= '0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      irqPrevQ <= irqIn;
      vecValid <= giveVec;
      if (giveVec) vecOut <= {baseQ, candIdx};
      if (strobe.initStart) begin
        irrQ  <= '0;
        isrQ  <= '0;
        imrQ  <= '0;
        cascQ <= '0;
      end else begin
        irrQ <= (irrQ & ~ackMask) | rise;
        isrQ <= isrAfterEoi | ackMask;
      end
      if (strobe.loadBase) baseQ <= wrData[DATA_W-1:IDX_W];
      if (strobe.loadCasc) cascQ <= wrData[NUM_IN-1:0];
      if (strobe.loadMask) imrQ  <= wrData[NUM_IN-1:0];
    end
  end

  AST_VEC_FROM_BASE: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecOut[DATA_W-1:IDX_W] == baseQ)); // R3

  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(intAck)); // R8

  AST_ACK_SETS_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    (ackHit && !strobe.initStart) |=> (isrQ != '0)); // R8

  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoi && !ackHit && isrQ != '0) |=>
      ($countones(isrQ) == $countones($past(isrQ)) - 1)); // R10

  AST_NO_INT_UNINIT: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.initStart) |-> !intOut); // R1

endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
  import pic_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8,
  parameter bit MASTER = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busWe,
  input  logic                      busAddr,
  input  logic [DATA_W-1:0]         busData,
  input  logic [NUM_IN-1:0]         irqIn,
  input  logic                      intAck,
  input  logic [$clog2(NUM_IN)-1:0] cascIn,
  input  logic                      cascEnIn,
  output logic                      intOut,
  output logic [$clog2(NUM_IN)-1:0] cascOut,
  output logic                      cascEnOut,
  output logic [DATA_W-1:0]         vecOut,
  output logic                      vecValid
);

  picStrobe_t strobe;

  pic_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busData (busData),
    .strobe  (strobe)
  );

  pic_dp #(.NUM_IN(NUM_IN), .DATA_W(DATA_W), .MASTER(MASTER)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (busData),
    .irqIn     (irqIn),
    .intAck    (intAck),
    .cascIn    (cascIn),
    .cascEnIn  (cascEnIn),
    .intOut    (intOut),
    .cascOut   (cascOut),
    .cascEnOut (cascEnOut),
    .vecOut    (vecOut),
    .vecValid  (vecValid)
  );

endmodule

// File: tb/test_cascade_pic.sv
module test_cascade_pic;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic       weM = 1'b0, weS = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] data = '0, irqM = '0, irqS = '0;
  logic       mInt, sInt, mCascEn, sCascEn, mVV, sVV;
  logic [2:0] mCasc, sCasc;
  logic [7:0] mVec, sVec;
  int checkCount = 0, failCount = 0;
  bit done = 1'b0;

  cascade_pic #(.MASTER(1'b1)) i_cascade_pic (
    .clk(clk), .rstN(rstN), .busWe(weM), .busAddr(addr), .busData(data),
    .irqIn({irqM[7:3], sInt, irqM[1:0]}), .intAck(ack),
    .cascIn(3'd0), .cascEnIn(1'b0),
    .intOut(mInt), .cascOut(mCasc), .cascEnOut(mCascEn),
    .vecOut(mVec), .vecValid(mVV));

  cascade_pic #(.MASTER(1'b0)) i_cascade_pic_slave (
    .clk(clk), .rstN(rstN), .busWe(weS), .busAddr(addr), .busData(data),
    .irqIn(irqS), .intAck(ack),
    .cascIn(mCasc), .cascEnIn(mCascEn),
    .intOut(sInt), .cascOut(sCasc), .cascEnOut(sCascEn),
    .vecOut(sVec), .vecValid(sVV));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit toSlave, input logic a, input logic [7:0] d);
    @(negedge clk);
    weM = !toSlave; weS = toSlave; addr = a; data = d;
    @(negedge clk);
    weM = 1'b0; weS = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit toSlave, input int idx);
    @(negedge clk);
    if (toSlave) irqS[idx] = 1'b1; else irqM[idx] = 1'b1;
    @(negedge clk);
    if (toSlave) irqS[idx] = 1'b0; else irqM[idx] = 1'b0;
    idle(3);
  endtask

  task automatic doAck(output logic valid, output logic [7:0] v);
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    valid = mVV | sVV;
    v = mVV ? mVec : sVec;
  endtask

  task automatic initPair(input logic [7:0] slaveId);
    wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
    wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, slaveId); wr(1, 1, 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired, all requirements, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic vld;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!mInt && !sInt && !mVV && !sVV, "R1 reset outputs", {mInt, sInt, mVV, sVV}, 0);
    pulse(0, 0);
    chk(!mInt, "R1 no interrupt before init", mInt, 0);
    doAck(vld, v);
    chk(!vld, "R1 ack before init", vld, 0);

    initPair(8'h02);
    // R2: mask cleared by init, request now accepted
    pulse(0, 1);
    chk(mInt, "R2 mask clear after init", mInt, 1);
    doAck(vld, v);
    chk(vld && v == 8'h21, "R2 R8 first vector", v, 8'h21);
    wr(0, 0, 8'h20);
    doAck(vld, v);
    chk(!vld, "R8 ack with nothing pending ignored", vld, 0);

    // R3 R8: sweep master local inputs
    for (int i = 0; i < 8; i++) begin
      if (i == 2) continue;
      pulse(0, i);
      chk(mInt, "R8 master raise", mInt, 1);
      doAck(vld, v);
      chk(vld && v == 8'(32 + i), "R3 master vector", v, 32 + i);
      chk(!mInt, "R7 in service blocks", mInt, 0);
      wr(0, 0, 8'h20);
    end

    // R9 R11: sweep slave inputs, EOI order alternates
    for (int j = 0; j < 8; j++) begin
      pulse(1, j);
      idle(1);
      chk(mInt, "R9 slave raises master", mInt, 1);
      doAck(vld, v);
      chk(vld && !mVV && v == 8'(40 + j), "R9 slave vector", v, 40 + j);
      if (j % 2 == 0) begin wr(1, 0, 8'h20); wr(0, 0, 8'h20); end
      else            begin wr(0, 0, 8'h20); wr(1, 0, 8'h20); end
      idle(2);
      chk(!mInt && !sInt, "R11 both retired", {mInt, sInt}, 0);
    end

    // R11: new slave request waits for the master EOI
    pulse(1, 5);
    idle(1);
    doAck(vld, v);
    chk(v == 8'h2D, "R11 slave vector", v, 8'h2D);
    wr(1, 0, 8'h20);
    pulse(1, 6);
    idle(1);
    chk(sInt && !mInt, "R11 held at master", {sInt, mInt}, 2);
    wr(0, 0, 8'h20);
    chk(mInt, "R11 released by master EOI", mInt, 1);
    doAck(vld, v);
    chk(vld && v == 8'h2E, "R11 delayed vector", v, 8'h2E);
    wr(1, 0, 8'h20); wr(0, 0, 8'h20);

    // R5: masked requests stay pending
    for (int i = 0; i < 8; i++) begin
      if (i == 2) continue;
      wr(0, 1, 8'(1 << i));
      pulse(0, i);
      chk(!mInt, "R5 masked input silent", mInt, 0);
      wr(0, 1, 8'h00);
      chk(mInt, "R5 pending after unmask", mInt, 1);
      doAck(vld, v);
      chk(v == 8'(32 + i), "R5 vector after unmask", v, 32 + i);
      wr(0, 0, 8'h20);
    end

    // R7 R10: nesting
    @(negedge clk); irqM[5] = 1'b1; irqM[3] = 1'b1;
    @(negedge clk); irqM[5] = 1'b0; irqM[3] = 1'b0;
    idle(2);
    doAck(vld, v);
    chk(v == 8'h23, "R7 lowest number first", v, 8'h23);
    chk(!mInt, "R7 lower priority blocked", mInt, 0);
    wr(0, 0, 8'h08);
    chk(!mInt, "R10 other command ignored", mInt, 0);
    pulse(0, 1);
    chk(mInt, "R7 higher pre-empts", mInt, 1);
    doAck(vld, v);
    chk(v == 8'h21, "R7 nested vector", v, 8'h21);
    wr(0, 0, 8'h20);
    chk(!mInt, "R10 retires lowest bit only", mInt, 0);
    wr(0, 0, 8'h20);
    chk(mInt, "R10 second EOI", mInt, 1);
    doAck(vld, v);
    chk(v == 8'h25, "R7 deferred vector", v, 8'h25);
    wr(0, 0, 8'h20);

    // R6: held level
    @(negedge clk); irqM[7] = 1'b1;
    idle(3);
    doAck(vld, v);
    chk(v == 8'h27, "R6 edge latched", v, 8'h27);
    wr(0, 0, 8'h20);
    idle(3);
    chk(!mInt, "R6 held level no repeat", mInt, 0);
    @(negedge clk); irqM[7] = 1'b0;

    // R9: mismatched slave identity
    initPair(8'h03);
    pulse(1, 0);
    idle(1);
    chk(mInt, "R9 master sees slave", mInt, 1);
    doAck(vld, v);
    chk(!vld, "R9 no vector on mismatch", vld, 0);
    chk(sInt, "R9 slave untouched", sInt, 1);

    // R2 R3 R4: single mode, no fourth word, base low bits ignored
    initPair(8'h02);
    wr(0, 0, 8'h12); wr(0, 1, 8'h47);
    wr(0, 1, 8'h00);
    pulse(0, 6);
    doAck(vld, v);
    chk(vld && v == 8'h46, "R3 base low bits ignored", v, 8'h46);
    wr(0, 0, 8'h20);
    pulse(1, 1);
    idle(1);
    doAck(vld, v);
    chk(vld && mVV && v == 8'h42, "R4 single mode no cascade", v, 8'h42);
    chk(sInt, "R4 slave not addressed", sInt, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule